// File: doc/BRIEF.md
# Triggered DAC Update Controller

This block is the register front end of a 10-bit current-output DAC. Software writes the new code as two bytes, a high byte and a low byte, and these bytes sit in holding registers. The code reaches the DAC input latch, which drives the converter, only when a chosen update event occurs. Because the event is picked in hardware, the output can follow a fixed sample rate no matter how late software makes its writes.

A 3-bit mode field in the control register selects the event. Four modes select one of four timer-overflow pulses. Three modes select the rising edge, the falling edge or either edge of an external convert-start pin, which is synchronised on chip. A last mode loads the latch right after the high byte is written. A 2-bit range field selects the full-scale current. The block reports the selected range and the output level as a multiple of the smallest current step.

Top module: `dac_trig_top`

## Requirements
- R1: Write and read addresses are 0 for control, 1 for high data and 2 for low data. Address 3 reads 0. Control holds mode in bits [6:4] and range in bits [1:0]; bits 7, 3 and 2 read 0. Low data keeps only bits [7:6]; bits [5:0] read 0 and writes to them are ignored.
- R2: Modes 0 to 3 load the latch on the clock edge where `timerOvf[mode]` is high. Pulses on the other timer inputs have no effect.
- R3: In every mode other than 7, writes to the data registers leave the latch unchanged until the selected event occurs.
- R4: A load copies all 10 bits in one step: the latch becomes high*4 + low[7:6].
- R5: Mode 4 loads on a rising edge of `convPin`, mode 5 on a falling edge and mode 6 on both edges. The pin passes through two synchroniser flops, so the latch changes on the third rising clock edge after the pin changes.
- R6: One pin edge causes exactly one load. Data written after that load stays in the holding registers.
- R7: In mode 7 the latch loads on the clock edge that follows the edge where the high data register is written. A low-byte write alone does not load it.
- R8: If a trigger comes on the same edge as a data write, the latch takes the value from before that write.
- R9: `fullScale` reads 2'b10 (2 mA) when range bit 1 is set, 2'b01 (1 mA) for range 01 and 2'b00 (0.5 mA) for range 00. `levelOut` equals the latch code shifted left by the `fullScale` value, in units of 0.5 mA/1024.
- R10: After reset the control register reads 0x02 (mode 0, 2 mA), the data registers and the latch are 0, `fullScale` is 2'b10 and `levelOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data for rdAddr (combinational) |
| timerOvf | input | 4 | Timer-overflow pulses, one per timer |
| convPin | input | 1 | External convert-start pin (asynchronous) |
| latchCode | output | 10 | DAC input latch |
| fullScale | output | 2 | Selected full-scale range |
| levelOut | output | 12 | Output level in steps of 0.5 mA/1024 |

## Verification
A wrong trigger select or a wrong edge detector shows up on `latchCode`. Either the latch loads on an event it should ignore, or it does not load on the edge it should, or it loads on a different edge. The bench finds this within one clock of the pulse, or within three clocks of a pin change. A load path that is out of step with the writes shows up as the latch holding the old value or a torn new value, on the one edge where the trigger and the write meet. A fault in the range decode shows up at once on `fullScale` and `levelOut`.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_HIGH = 2'd1;
  localparam logic [1:0] ADDR_LOW  = 2'd2;

  typedef enum logic [2:0] {
    MODE_TMR0   = 3'd0,
    MODE_TMR1   = 3'd1,
    MODE_TMR2   = 3'd2,
    MODE_TMR3   = 3'd3,
    MODE_RISE   = 3'd4,
    MODE_FALL   = 3'd5,
    MODE_BOTH   = 3'd6,
    MODE_DIRECT = 3'd7
  } updMode_t;

  typedef struct packed {
    logic wrCtrl;
    logic wrHigh;
    logic wrLow;
    logic loadLatch;
  } dacStrobe_t;

endpackage

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
  import dac_trig_pkg::*;
#(
  parameter int NUM_TIMERS  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  updMode_t              mode,
  input  logic [NUM_TIMERS-1:0] timerOvf,
  input  logic                  convPin,
  output dacStrobe_t            strobe
);

  localparam int TSEL_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinNow;
  logic                   pinPrev;
  logic                   riseHit;
  logic                   fallHit;
  logic                   timerHit;
  logic                   edgeHit;
  logic                   directPend;
  logic [NUM_TIMERS-1:0]  timerSel;

  // synchroniser chain for the asynchronous pin
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= convPin;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], convPin};
      end
    end
  endgenerate

  assign pinNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= pinNow;
  end

  assign riseHit = pinNow & ~pinPrev;
  assign fallHit = ~pinNow & pinPrev;

  // one-hot decode of the timer number in the mode field
  generate
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tsel
      assign timerSel[t] = (mode[2] == 1'b0) && (mode[TSEL_W-1:0] == TSEL_W'(t));
    end
  endgenerate

  assign timerHit = |(timerSel & timerOvf);

  always_comb begin
    unique case (mode)
      MODE_RISE: edgeHit = riseHit;
      MODE_FALL: edgeHit = fallHit;
      MODE_BOTH: edgeHit = riseHit | fallHit;
      default:   edgeHit = 1'b0;
    endcase
  end

  // direct mode: load one cycle after a high-byte write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) directPend <= 1'b0;
    else       directPend <= wrEn && (wrAddr == ADDR_HIGH) && (mode == MODE_DIRECT);
  end

  always_comb begin
    strobe.wrCtrl    = wrEn && (wrAddr == ADDR_CTRL);
    strobe.wrHigh    = wrEn && (wrAddr == ADDR_HIGH);
    strobe.wrLow     = wrEn && (wrAddr == ADDR_LOW);
    strobe.loadLatch = (mode == MODE_DIRECT) ? directPend : (timerHit | edgeHit);
  end

  // R2: a timer-mode load needs the selected overflow input
  a_r2_timer_source: assert property (@(posedge clk) disable iff (!rstN)
    (!mode[2] && strobe.loadLatch) |-> timerOvf[mode[TSEL_W-1:0]]);

  // R6: an edge-mode load needs a change on the synchronised pin
  a_r6_edge_needs_change: assert property (@(posedge clk) disable iff (!rstN)
    (mode[2] && mode != MODE_DIRECT && strobe.loadLatch) |-> (pinNow != pinPrev));

  // R7: a high-byte write in direct mode is followed by a load
  a_r7_direct_follows: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_HIGH && mode == MODE_DIRECT) |=>
      (mode != MODE_DIRECT || strobe.loadLatch));

endmodule

// File: rtl/dac_trig_datapath.sv
module dac_trig_datapath
  import dac_trig_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int LEVEL_W = CODE_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dacStrobe_t        strobe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output updMode_t          mode,
  output logic [CODE_W-1:0] latchCode,
  output logic [1:0]        fullScale,
  output logic [LEVEL_W-1:0] levelOut
);

  localparam int LOW_W = CODE_W - BYTE_W;

  logic [BYTE_W-1:0] highReg;
  logic [LOW_W-1:0]  lowReg;
  logic [1:0]        rangeReg;
  logic [CODE_W-1:0] holdCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_TMR0;
      rangeReg <= 2'b10;
    end else if (strobe.wrCtrl) begin
      mode     <= updMode_t'(wrData[6:4]);
      rangeReg <= wrData[1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highReg <= '0;
      lowReg  <= '0;
    end else begin
      if (strobe.wrHigh) highReg <= wrData;
      if (strobe.wrLow)  lowReg  <= wrData[BYTE_W-1 -: LOW_W];
    end
  end

  assign holdCode = {highReg, lowReg};

  // the load samples the pre-write holding value on a shared edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 latchCode <= '0;
    else if (strobe.loadLatch) latchCode <= holdCode;
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL: rdData = {1'b0, mode, 2'b00, rangeReg};
      ADDR_HIGH: rdData = highReg;
      ADDR_LOW:  rdData = {lowReg, {(BYTE_W-LOW_W){1'b0}}};
      default:   rdData = '0;
    endcase
  end

  assign fullScale = rangeReg[1] ? 2'b10 : {1'b0, rangeReg[0]};
  assign levelOut  = LEVEL_W'(latchCode) << fullScale;

  // R3: without a load strobe the latch holds
  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadLatch |=> $stable(latchCode));

  // R4: a load copies the full holding word seen on that edge
  a_r4_full_copy: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLatch |=> (latchCode == $past(holdCode)));

  // R9: the level is never below the raw code
  a_r9_level_scaled: assert property (@(posedge clk) disable iff (!rstN)
    levelOut >= LEVEL_W'(latchCode));

endmodule

// File: rtl/dac_trig_top.sv
module dac_trig_top
  import dac_trig_pkg::*;
#(
  parameter int CODE_W      = 10,
  parameter int BYTE_W      = 8,
  parameter int NUM_TIMERS  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_W     = CODE_W + 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [BYTE_W-1:0]     wrData,
  input  logic [1:0]            rdAddr,
  output logic [BYTE_W-1:0]     rdData,
  input  logic [NUM_TIMERS-1:0] timerOvf,
  input  logic                  convPin,
  output logic [CODE_W-1:0]     latchCode,
  output logic [1:0]            fullScale,
  output logic [LEVEL_W-1:0]    levelOut
);

  dacStrobe_t strobe;
  updMode_t   mode;

  dac_trig_ctrl #(
    .NUM_TIMERS (NUM_TIMERS),
    .SYNC_STAGES(SYNC_STAGES),
    .ADDR_W     (2)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .mode    (mode),
    .timerOvf(timerOvf),
    .convPin (convPin),
    .strobe  (strobe)
  );

  dac_trig_datapath #(
    .CODE_W (CODE_W),
    .BYTE_W (BYTE_W),
    .ADDR_W (2),
    .LEVEL_W(LEVEL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .mode     (mode),
    .latchCode(latchCode),
    .fullScale(fullScale),
    .levelOut (levelOut)
  );

endmodule

// File: tb/tb_dac_trig_top.sv
module tb_dac_trig_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [7:0]  wrData = 8'd0;
  logic [1:0]  rdAddr = 2'd0;
  logic [7:0]  rdData;
  logic [3:0]  timerOvf = 4'd0;
  logic        convPin = 1'b0;
  logic [9:0]  latchCode;
  logic [1:0]  fullScale;
  logic [11:0] levelOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_trig_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .timerOvf(timerOvf), .convPin(convPin),
    .latchCode(latchCode), .fullScale(fullScale), .levelOut(levelOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [1:0] a, input int exp, input string req);
    rdAddr = a;
    #1;
    chk(rdData == exp, req, rdData, exp);
  endtask

  task automatic setCode(input int code);
    wrReg(2'd2, 8'((code & 3) << 6) | 8'h15);
    wrReg(2'd1, 8'(code >> 2));
  endtask

  task automatic pulseTimer(input int t);
    @(negedge clk);
    timerOvf[t] = 1'b1;
    @(negedge clk);
    timerOvf = 4'd0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int prev;
    int code;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    rdChk(2'd0, 8'h02, "R10 ctrl");
    rdChk(2'd1, 0, "R10 high");
    rdChk(2'd2, 0, "R10 low");
    chk(latchCode == 0, "R10 latch", latchCode, 0);
    chk(fullScale == 2'b10, "R10 range", fullScale, 2);
    chk(levelOut == 0, "R10 level", levelOut, 0);

    // R1 register map
    wrReg(2'd0, 8'hFF);
    rdChk(2'd0, 8'h73, "R1 ctrl unused bits");
    wrReg(2'd0, 8'h02);
    wrReg(2'd2, 8'hFF);
    rdChk(2'd2, 8'hC0, "R1 low unused bits");
    wrReg(2'd1, 8'hA5);
    rdChk(2'd1, 8'hA5, "R1 high");
    rdChk(2'd3, 0, "R1 spare address");
    chk(latchCode == 0, "R3 no load in mode 0", latchCode, 0);

    // R2/R3/R4 timer modes, all timers against each mode
    prev = 0;
    for (int m = 0; m < 4; m++) begin
      wrReg(2'd0, 8'((m << 4) | 2));
      code = 100 + m * 211;
      setCode(code);
      chk(latchCode == prev, "R3 held after writes", latchCode, prev);
      for (int t = 0; t < 4; t++) begin
        if (t != m) begin
          pulseTimer(t);
          chk(latchCode == prev, "R2 other timer ignored", latchCode, prev);
        end
      end
      pulseTimer(m);
      chk(latchCode == code, "R4 load on selected timer", latchCode, code);
      prev = code;
    end

    // R8 trigger on the same edge as a write (mode 3 still selected)
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd1; wrData = 8'h11; timerOvf[3] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; timerOvf = 4'd0;
    chk(latchCode == prev, "R8 pre-write value", latchCode, prev);
    code = (8'h11 << 2) | (prev & 3);
    pulseTimer(3);
    chk(latchCode == code, "R8 new value next trigger", latchCode, code);
    prev = code;

    // R5/R6 pin edge modes
    for (int m = 4; m < 7; m++) begin
      wrReg(2'd0, 8'((m << 4) | 2));
      for (int e = 0; e < 2; e++) begin
        bit hit;
        code = 37 + m * 97 + e * 301;
        setCode(code);
        hit = (m == 6) || (m == 4 && e == 0) || (m == 5 && e == 1);
        @(negedge clk);
        convPin = (e == 0);
        @(negedge clk);
        @(negedge clk);
        chk(latchCode == prev, "R5 not before third edge", latchCode, prev);
        @(negedge clk);
        if (hit) begin
          chk(latchCode == code, "R5 load on chosen edge", latchCode, code);
          prev = code;
        end else begin
          chk(latchCode == prev, "R5 other edge ignored", latchCode, prev);
        end
        repeat (3) @(negedge clk);
        setCode(code ^ 10'h2AA);
        repeat (4) @(negedge clk);
        chk(latchCode == prev, "R6 single load per edge", latchCode, prev);
      end
    end

    // R7/R9 direct mode sweep over ranges and codes
    for (int r = 0; r < 4; r++) begin
      int sh;
      sh = (r >= 2) ? 2 : r;
      wrReg(2'd0, 8'(8'h70 | r));
      @(negedge clk);
      prev = latchCode;
      chk(fullScale == sh, "R9 range decode", fullScale, sh);
      for (int c = 0; c < 1024; c += 31) begin
        code = (c == 1023 - 1023 % 31) ? 1023 : c;
        wrReg(2'd2, 8'((code & 3) << 6));
        @(negedge clk);
        chk(latchCode == prev, "R7 low write no load", latchCode, prev);
        wrReg(2'd1, 8'(code >> 2));
        chk(latchCode == prev, "R7 load not yet", latchCode, prev);
        @(negedge clk);
        chk(latchCode == code, "R7 load after high write", latchCode, code);
        chk(levelOut == (code << sh), "R9 level", levelOut, code << sh);
        prev = code;
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule